// File: doc/BRIEF.md
# Small-Page NAND Flash Read Responder

This block answers a host that drives an 8-bit parallel flash bus with latch-enable and strobe lines, and it behaves as the read side of a small-page NAND memory. Two chip-select lanes share the bus. Each lane keeps its own read mode, address-cycle counter, byte pointer, ready line and error flag, and each has its own byte array. A lane is filled through a side write port that exists for preloading only. A page holds 528 bytes. The three read modes start the column at offset 0x000, 0x100 or 0x200. The page number arrives in two address bytes, high byte first.

All bus pins are sampled on the clock, and an action fires only once for each falling strobe. A command or address byte is taken when the write strobe falls. A data byte is returned when the read strobe falls, and the pointer then advances by one, so a read stream runs across page boundaries on its own. The block has no valid/ready handshake. The host's read strobe paces the data, one byte per falling edge. The host cannot stall the block and the block cannot stall the host, so there is no back-pressure in either direction. The ready lines never report busy.

Top module: `nand_rd_responder`

## Requirements
- R1: After reset, bus_oe is 0, bus_out is 0xFF, and every bit of rdy and err is 0.
- R2: A lane is selected when its ce_n bit is low. When both bits are low, lane 0 wins. When neither is low, no lane state changes and bus_oe falls to 0. Each lane's pointer moves only when that lane is selected.
- R3: When a lane is selected with re_n and we_n both high (idle), that lane's rdy bit goes to 1 and then stays 1, and bus_oe falls to 0.
- R4: When we_n falls with cle high, bus_in is a command. 0x00 selects read mode A, 0x01 selects mode B and 0x50 selects mode C, and each clears the address-cycle counter. 0xFF returns the lane to the wait state.
- R5: When we_n falls with ale high and cle low, bus_in is an address byte. The first address byte sets the pointer to the byte OR the mode offset: 0x000 for mode A, 0x100 for mode B, 0x200 for mode C.
- R6: The second address byte adds byte×528×256 to the pointer, and the third adds byte×528.
- R7: When re_n falls with cle and ale low, the byte at the pointer appears on bus_out with bus_oe at 1, and the pointer then advances by one, across page boundaries.
- R8: Each falling strobe causes exactly one action. Holding re_n or we_n low does not repeat it.
- R9: A location that was never preloaded, or that lies at or beyond the array depth (528×ARRAY_PAGES), reads as 0xFF.
- R10: Any of these sets the lane's err bit until reset and leaves the mode and pointer unchanged: an unknown command, an address byte in the wait state, or a fourth address byte.
- R11: If a preload write and a bus read hit the same byte in the same clock, the read returns the old content. The new content is returned by a later read.
- R12: The result of a falling strobe becomes visible on the outputs after the second rising clock edge that follows the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | LANES (2) | Active-low lane selects, bit 0 has priority |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| re_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| bus_in | input | 8 | Bus byte from host |
| bus_out | output | 8 | Read data byte |
| bus_oe | output | 1 | Drive enable for bus_out |
| rdy | output | LANES (2) | Per-lane ready, never busy |
| err | output | LANES (2) | Per-lane sticky protocol error |
| bd_we | input | 1 | Preload write enable |
| bd_lane | input | 1 | Preload target lane |
| bd_idx | input | IDX_W (11) | Preload byte index |
| bd_data | input | 8 | Preload byte |

## Verification
A preload write and a bus read can land on the same byte of the same lane in the same clock. The bench provokes this by raising bd_we in exactly the cycle where the sampled read-strobe fall is acted on. It judges the result by requiring the old byte on the bus, and the new byte after the same location is addressed again. A second collision happens when both lane selects are low together. In that case the bench checks that the returned byte follows lane 0's pointer and that lane 1's pointer has not moved.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

  typedef enum logic [1:0] {
    LM_WAIT = 2'd0,
    LM_RD_A = 2'd1,
    LM_RD_B = 2'd2,
    LM_RD_C = 2'd3
  } lane_mode_t;

  localparam logic [7:0] OP_RESET = 8'hFF;
  localparam logic [7:0] OP_RD_A  = 8'h00;
  localparam logic [7:0] OP_RD_B  = 8'h01;
  localparam logic [7:0] OP_RD_C  = 8'h50;

  localparam int unsigned ADDR_BYTES = 3;

  function automatic logic [9:0] col_offset(lane_mode_t m);
    case (m)
      LM_RD_B: col_offset = 10'h100;
      LM_RD_C: col_offset = 10'h200;
      default: col_offset = 10'h000;
    endcase
  endfunction

endpackage

// File: rtl/nand_strobe_sync.sv
module nand_strobe_sync #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             re_n,
  input  logic             we_n,
  input  logic [7:0]       din,
  output logic [LANES-1:0] sel_vec,
  output logic             idle,
  output logic             cmd_ev,
  output logic             adr_ev,
  output logic             rd_ev,
  output logic [7:0]       byte_q
);

  logic [LANES-1:0] s_ce_n;
  logic             s_cle, s_ale, s_re_n, s_we_n;
  logic             p_re_n, p_we_n;
  logic             any_sel, re_fall, we_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce_n <= '1;
      s_cle  <= 1'b0;
      s_ale  <= 1'b0;
      s_re_n <= 1'b1;
      s_we_n <= 1'b1;
      p_re_n <= 1'b1;
      p_we_n <= 1'b1;
      byte_q <= '0;
    end else begin
      s_ce_n <= ce_n;
      s_cle  <= cle;
      s_ale  <= ale;
      s_re_n <= re_n;
      s_we_n <= we_n;
      p_re_n <= s_re_n;
      p_we_n <= s_we_n;
      byte_q <= din;
    end
  end

  // lowest selected lane wins
  always_comb begin
    sel_vec = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (!s_ce_n[i]) sel_vec = LANES'(1) << i;
    end
  end

  assign any_sel = |sel_vec;
  assign idle    = s_re_n & s_we_n;
  assign re_fall = p_re_n & ~s_re_n;
  assign we_fall = p_we_n & ~s_we_n;

  assign cmd_ev = any_sel & ~idle & s_cle & we_fall;
  assign adr_ev = any_sel & ~idle & ~s_cle & s_ale & we_fall;
  assign rd_ev  = any_sel & ~idle & ~s_cle & ~s_ale & re_fall;

endmodule

// File: rtl/nand_lane_ctrl.sv
module nand_lane_ctrl
  import nand_rd_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int PAGE_BYTES = 528
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              idle,
  input  logic              cmd_ev,
  input  logic              adr_ev,
  input  logic              rd_ev,
  input  logic [7:0]        byte_in,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        cyc,
  output logic              rdy,
  output logic              err
);

  localparam logic [ADDR_W-1:0] PAGE_STEP  = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] BLOCK_STEP = ADDR_W'(PAGE_BYTES * 256);
  localparam logic [1:0]        LAST_CYC   = 2'(ADDR_BYTES);

  lane_mode_t        mode;
  logic [ADDR_W-1:0] byte_w;

  assign byte_w = ADDR_W'(byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= LM_WAIT;
      addr <= '0;
      cyc  <= '0;
      rdy  <= 1'b0;
      err  <= 1'b0;
    end else if (sel) begin
      if (idle) rdy <= 1'b1;

      if (cmd_ev) begin
        case (byte_in)
          OP_RESET: mode <= LM_WAIT;
          OP_RD_A:  begin mode <= LM_RD_A; cyc <= '0; end
          OP_RD_B:  begin mode <= LM_RD_B; cyc <= '0; end
          OP_RD_C:  begin mode <= LM_RD_C; cyc <= '0; end
          default:  err <= 1'b1;
        endcase
      end

      if (adr_ev) begin
        if (mode == LM_WAIT || cyc == LAST_CYC) begin
          err <= 1'b1;
        end else begin
          case (cyc)
            2'd0:    addr <= byte_w | ADDR_W'(col_offset(mode));
            2'd1:    addr <= addr + byte_w * BLOCK_STEP;
            default: addr <= addr + byte_w * PAGE_STEP;
          endcase
          cyc <= cyc + 2'd1;
        end
      end

      if (rd_ev) addr <= addr + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/nand_lane_array.sv
module nand_lane_array #(
  parameter int DEPTH  = 1584,
  parameter int ADDR_W = 26,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] written;
  logic             in_range, wr_ok;
  logic [IDX_W-1:0] rd_idx;

  assign in_range = rd_addr < ADDR_W'(DEPTH);
  assign rd_idx   = rd_addr[IDX_W-1:0];
  assign wr_ok    = wr_en && (32'(wr_idx) < 32'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written <= '0;
      rd_data <= 8'hFF;
    end else begin
      if (wr_ok) written[wr_idx] <= 1'b1;
      if (rd_en) rd_data <= (in_range && written[rd_idx]) ? mem[rd_idx] : 8'hFF;
    end
  end

endmodule

// File: rtl/nand_rd_responder.sv
module nand_rd_responder #(
  parameter int LANES       = 2,
  parameter int PAGE_BYTES  = 528,
  parameter int ARRAY_PAGES = 3,
  parameter int ADDR_W      = 26,
  parameter int DEPTH       = PAGE_BYTES * ARRAY_PAGES,
  parameter int IDX_W       = $clog2(DEPTH),
  parameter int LANE_W      = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              re_n,
  input  logic              we_n,
  input  logic [7:0]        bus_in,
  output logic [7:0]        bus_out,
  output logic              bus_oe,
  output logic [LANES-1:0]  rdy,
  output logic [LANES-1:0]  err,
  input  logic              bd_we,
  input  logic [LANE_W-1:0] bd_lane,
  input  logic [IDX_W-1:0]  bd_idx,
  input  logic [7:0]        bd_data
);

  logic [LANES-1:0]  sel_vec;
  logic              idle, cmd_ev, adr_ev, rd_ev;
  logic [7:0]        byte_q;
  logic [LANE_W-1:0] sel_idx, rd_lane_q;
  logic [ADDR_W-1:0] lane_addr  [LANES];
  logic [1:0]        lane_cyc   [LANES];
  logic [7:0]        lane_rdata [LANES];

  nand_strobe_sync #(.LANES(LANES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .cle    (cle),
    .ale    (ale),
    .re_n   (re_n),
    .we_n   (we_n),
    .din    (bus_in),
    .sel_vec(sel_vec),
    .idle   (idle),
    .cmd_ev (cmd_ev),
    .adr_ev (adr_ev),
    .rd_ev  (rd_ev),
    .byte_q (byte_q)
  );

  always_comb begin
    sel_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (sel_vec[i]) sel_idx = LANE_W'(i);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    nand_lane_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel_vec[g]),
      .idle   (idle),
      .cmd_ev (cmd_ev),
      .adr_ev (adr_ev),
      .rd_ev  (rd_ev),
      .byte_in(byte_q),
      .addr   (lane_addr[g]),
      .cyc    (lane_cyc[g]),
      .rdy    (rdy[g]),
      .err    (err[g])
    );

    nand_lane_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_arr (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_ev && sel_vec[g]),
      .rd_addr(lane_addr[g]),
      .wr_en  (bd_we && (bd_lane == LANE_W'(g))),
      .wr_idx (bd_idx),
      .wr_data(bd_data),
      .rd_data(lane_rdata[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_oe    <= 1'b0;
      rd_lane_q <= '0;
    end else if (!(|sel_vec) || idle) begin
      bus_oe <= 1'b0;
    end else if (rd_ev) begin
      bus_oe    <= 1'b1;
      rd_lane_q <= sel_idx;
    end
  end

  assign bus_out = lane_rdata[rd_lane_q];

endmodule

// File: rtl/nand_rd_responder_chk.sv
module nand_rd_responder_chk #(
  parameter int LANES  = 2,
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LANES-1:0]  rdy,
  input logic [LANES-1:0]  err,
  input logic              bus_oe,
  input logic [LANES-1:0]  sel_vec,
  input logic              idle,
  input logic              rd_ev,
  input logic              adr_ev,
  input logic [ADDR_W-1:0] addr0,
  input logic [1:0]        cyc0
);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    a_r3_rdy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      rdy[g] |=> rdy[g]);
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err[g] |=> err[g]);
  end

  a_r2_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|sel_vec) || idle) |=> !bus_oe);

  a_r7_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && sel_vec[0]) |=> (addr0 == $past(addr0) + ADDR_W'(1)));

  a_r10_extra_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_ev && sel_vec[0] && cyc0 == 2'd3) |=> $stable(addr0));

  a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> !rd_ev);

endmodule

bind nand_rd_responder nand_rd_responder_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rdy    (rdy),
  .err    (err),
  .bus_oe (bus_oe),
  .sel_vec(sel_vec),
  .idle   (idle),
  .rd_ev  (rd_ev),
  .adr_ev (adr_ev),
  .addr0  (lane_addr[0]),
  .cyc0   (lane_cyc[0])
);

// File: tb/sim_nand_rd_responder.sv
module sim_nand_rd_responder;

  localparam int CLK_PERIOD = 10;
  localparam int PAGE       = 528;
  localparam int DEPTH      = PAGE * 3;
  localparam int IDX_W      = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       ce_n = 2'b11;
  logic             cle = 1'b0, ale = 1'b0, re_n = 1'b1, we_n = 1'b1;
  logic [7:0]       bus_in = '0;
  logic [7:0]       bus_out;
  logic             bus_oe;
  logic [1:0]       rdy, err;
  logic             bd_we = 1'b0;
  logic [0:0]       bd_lane = '0;
  logic [IDX_W-1:0] bd_idx = '0;
  logic [7:0]       bd_data = '0;

  int checks = 0;
  int fails  = 0;
  logic [7:0] ref_mem [2][DEPTH];
  bit         ref_wr  [2][DEPTH];
  int unsigned ptr [2];

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_rd_responder u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .re_n(re_n), .we_n(we_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .rdy(rdy), .err(err), .bd_we(bd_we),
    .bd_lane(bd_lane), .bd_idx(bd_idx), .bd_data(bd_data)
  );

  function automatic int unsigned exp_addr(int m, int col, int hi, int lo);
    return (col | ((m - 1) * 256)) + hi * PAGE * 256 + lo * PAGE;
  endfunction

  function automatic logic [7:0] exp_byte(int lane, int unsigned a);
    if (a < DEPTH && ref_wr[lane][a]) return ref_mem[lane][a];
    return 8'hFF;
  endfunction

  function automatic logic [1:0] ce_of(int lane);
    return (lane == 0) ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cycle(logic [1:0] ce, logic is_cmd, logic [7:0] b);
    ce_n = ce; cle = is_cmd; ale = !is_cmd; bus_in = b; we_n = 1'b0;
    waitn(3);
    we_n = 1'b1;
    waitn(3);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic rd_cycle(logic [1:0] ce, output logic [7:0] b, output logic oe);
    ce_n = ce; cle = 1'b0; ale = 1'b0; re_n = 1'b0;
    waitn(3);
    b = bus_out; oe = bus_oe;
    re_n = 1'b1;
    waitn(3);
  endtask

  task automatic setup_read(int lane, int m, int col, int hi, int lo);
    logic [7:0] op;
    op = (m == 1) ? 8'h00 : (m == 2) ? 8'h01 : 8'h50;
    wr_cycle(ce_of(lane), 1'b1, op);
    wr_cycle(ce_of(lane), 1'b0, 8'(col));
    wr_cycle(ce_of(lane), 1'b0, 8'(hi));
    wr_cycle(ce_of(lane), 1'b0, 8'(lo));
    ptr[lane] = exp_addr(m, col, hi, lo);
  endtask

  task automatic read_chk(int lane, string req);
    logic [7:0] b; logic oe;
    rd_cycle(ce_of(lane), b, oe);
    chk(req, b, exp_byte(lane, ptr[lane]));
    chk(req, oe, 1'b1);
    ptr[lane]++;
  endtask

  task automatic preload(int lane, int idx, logic [7:0] v);
    bd_we = 1'b1; bd_lane = 1'(lane); bd_idx = IDX_W'(idx); bd_data = v;
    @(negedge clk);
    bd_we = 1'b0;
    ref_mem[lane][idx] = v;
    ref_wr[lane][idx] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails + 1);
    $finish;
  end

  initial begin
    logic [7:0] b, oldv;
    logic oe;
    int unsigned p0, p1;
    void'($urandom(32'd4242));
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < DEPTH; i++) ref_wr[l][i] = 1'b0;

    waitn(3);
    // R1 reset state
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 bus_out", bus_out, 8'hFF);
    chk("R1 rdy", rdy, 0);
    chk("R1 err", err, 0);
    rst_n = 1'b1;
    waitn(2);

    // preload pages 0 and 1 of both lanes; page 2 stays blank
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < 2 * PAGE; i++)
        if (($urandom % 4) != 0) preload(l, i, 8'($urandom));

    // R3 idle raises ready and releases bus
    ce_n = 2'b10; waitn(3);
    ce_n = 2'b01; waitn(3);
    chk("R3 rdy", rdy, 2'b11);
    chk("R3 bus_oe", bus_oe, 0);

    // R4 R5 R6 R7 mode A, column 5, page 1
    setup_read(0, 1, 5, 0, 1);
    chk("R6 pointer", ptr[0], 533);
    for (int k = 0; k < 4; k++) read_chk(0, "R7 mode A stream");

    // R5 R7 mode C, column 0x0F = 527, crossing into page 1
    setup_read(1, 3, 8'h0F, 0, 0);
    for (int k = 0; k < 3; k++) read_chk(1, "R7 page crossing");

    // R8 holding the read strobe low yields one advance
    ce_n = 2'b10; re_n = 1'b0;
    waitn(12);
    chk("R8 held read byte", bus_out, exp_byte(0, ptr[0]));
    re_n = 1'b1; waitn(3);
    ptr[0]++;
    read_chk(0, "R8 next after hold");

    // R2 priority with both selects low, lane 1 untouched
    p0 = ptr[0]; p1 = ptr[1];
    rd_cycle(2'b00, b, oe);
    chk("R2 priority lane0", b, exp_byte(0, p0));
    ptr[0]++;
    read_chk(1, "R2 lane1 pointer unmoved");
    chk("R2 lane1 expected ptr", ptr[1], p1 + 1);

    // R2 no select: strobe ignored, bus released
    ce_n = 2'b11; re_n = 1'b0; waitn(4);
    chk("R2 no select oe", bus_oe, 0);
    re_n = 1'b1; waitn(3);
    read_chk(0, "R2 no-select read had no effect");

    // R9 blank page and beyond array
    setup_read(0, 2, 3, 0, 2);
    read_chk(0, "R9 blank page");
    setup_read(1, 1, 0, 1, 0);
    read_chk(1, "R9 beyond depth");
    chk("R9 beyond depth value", bus_out, 8'hFF);

    // R10 errors
    chk("R10 no error yet", err, 0);
    setup_read(0, 1, 10, 0, 0);
    read_chk(0, "R10 pre-error read");
    wr_cycle(ce_of(0), 1'b1, 8'h33);
    chk("R10 unknown cmd err", err, 2'b01);
    read_chk(0, "R10 state kept after unknown cmd");
    setup_read(0, 2, 7, 0, 1);
    wr_cycle(ce_of(0), 1'b0, 8'h99);
    read_chk(0, "R10 fourth address ignored");
    wr_cycle(ce_of(1), 1'b1, 8'hFF);
    wr_cycle(ce_of(1), 1'b0, 8'h12);
    chk("R10 address in wait err", err, 2'b11);
    read_chk(1, "R4 wait state keeps pointer");

    // R11 same-cycle preload and read of the same byte
    setup_read(0, 1, 100, 0, 0);
    oldv = exp_byte(0, 100);
    ce_n = 2'b10; re_n = 1'b0;
    @(negedge clk);
    bd_we = 1'b1; bd_lane = 1'b0; bd_idx = IDX_W'(100); bd_data = ~oldv;
    @(negedge clk);
    bd_we = 1'b0;
    chk("R11 old data on collision", bus_out, oldv);
    chk("R12 output at second edge", bus_oe, 1);
    ref_mem[0][100] = ~oldv; ref_wr[0][100] = 1'b1;
    re_n = 1'b1; waitn(3);
    setup_read(0, 1, 100, 0, 0);
    read_chk(0, "R11 new data later");

    // random streams, R4 R5 R6 R7
    for (int it = 0; it < 40; it++) begin
      int lane, m, col, lo, n;
      lane = $urandom % 2;
      m    = 1 + ($urandom % 3);
      col  = $urandom % 256;
      lo   = $urandom % 3;
      n    = 1 + ($urandom % 6);
      setup_read(lane, m, col, 0, lo);
      for (int k = 0; k < n; k++) read_chk(lane, "R5 R6 random stream");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule